// File: doc/BRIEF.md
# Slave-serial configuration loader

This block brings up a downstream FPGA that is set to slave-serial mode. The configuration image sits in a byte-wide memory. A start strobe makes the block read an eight-byte header from that memory, check it, and then run the configuration handshake on four pins. First it pulses the program pin low and watches the init pin. Then it shifts the payload out one bit per serial clock. Finally it keeps clocking all-ones fill bytes until the target reports done.

The header holds two 32-bit words, each stored most significant byte first. The first is a fixed magic word, default 0x5352544D ("SRTM"). The second is the payload length in bytes, which may not exceed MAX_LEN (default 0x220000). The program low pulse is 1 ms long. The wait for initialization to finish is 10 ms. The time allowed for done after the last payload byte is 100 ms. All three windows are computed from the CLK_HZ parameter.

When the load ends, the block drops busy and raises exactly one of ok or err. It also leaves an error code and a warning flag. These outputs keep their values until the next start.

Top module: `slave_cfg_loader`

## Requirements
- R1: Header bytes 0..3, most significant byte first, must equal MAGIC. If they do not, the load ends with err_code 1, and cfg_drive never rises.
- R2: Header bytes 4..7, most significant byte first, are the payload length. A length above MAX_LEN ends the load with err_code 2 and no pin activity. A length equal to MAX_LEN is accepted.
- R3: Once the header is valid, cfg_drive rises. cfg_prog_b is then held low for exactly CLK_HZ/1000 clock cycles, and cfg_cclk and cfg_din stay low throughout.
- R4: If the synchronized init pin is high at the end of the program pulse, the load ends with err_code 3 and no serial clock is sent.
- R5: After cfg_prog_b rises, no serial clock edge occurs for at least CLK_HZ/100 cycles. If the init pin is then low, the load ends with err_code 4.
- R6: Payload bytes are sent in address order starting at address 8, most significant bit first. cfg_din holds steady while cfg_cclk is high, and cfg_cclk is high for CCLK_HALF cycles per bit.
- R7: The init pin is checked after each payload byte. If it is low, the load ends with err_code 5 before the remaining payload is sent.
- R8: After the payload, if the done pin is low, the block sends 0xFF bytes until it sees done. It then ends with ok=1 and err_code 0.
- R9: If done is still missing CLK_HZ/10 cycles after the last payload byte, the load ends with err_code 6. Every fill byte sent before that point is 0xFF.
- R10: done_warn is set if the done pin is already high when the header is accepted. The load still runs to completion, and no fill byte is sent if done stays high.
- R11: After reset, busy, ok, err, err_code, cfg_drive and cfg_cclk are all 0. busy stays high from start until exactly one of ok or err rises. After that, the status outputs hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle strobe that begins a load |
| mem_rd | output | 1 | Image memory read enable |
| mem_addr | output | ADDR_W | Image memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| cfg_drive | output | 1 | Output enable for cfg_prog_b, cfg_cclk and cfg_din |
| cfg_prog_b | output | 1 | Program pin, active low |
| cfg_cclk | output | 1 | Serial configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init_b | input | 1 | Init pin from the target, asynchronous |
| cfg_done | input | 1 | Done pin from the target, asynchronous |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load succeeded |
| err | output | 1 | Last load failed |
| err_code | output | 3 | Failure cause, 1 to 6 as in R1 to R9, 0 when none |
| done_warn | output | 1 | Done was already high before loading |

## Verification
The bench builds the block with CLK_HZ = 20000. This shrinks the 1 ms, 10 ms and 100 ms windows to 20, 200 and 2000 cycles, which makes the exact program pulse width and the done timeout cheap to reach. CCLK_HALF = 2 keeps each byte short. MAX_LEN = 12 allows both sides of the length limit to be tested with a 64-byte image. A behavioural model of the target drives init and done back in response to the pins, so every error path can be triggered on purpose.

// File: rtl/slave_cfg_loader.sv
module slave_cfg_loader #(
  parameter int          CLK_HZ    = 100_000_000,
  parameter int          CCLK_HALF = 2,
  parameter int          ADDR_W    = 24,
  parameter logic [31:0] MAGIC     = 32'h5352_544D,
  parameter logic [31:0] MAX_LEN   = 32'h0022_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              cfg_drive,
  output logic              cfg_prog_b,
  output logic              cfg_cclk,
  output logic              cfg_din,
  input  logic              cfg_init_b,
  input  logic              cfg_done,
  output logic              busy,
  output logic              ok,
  output logic              err,
  output logic [2:0]        err_code,
  output logic              done_warn
);
  localparam logic [31:0] PROG_CYC = 32'(CLK_HZ / 1000);
  localparam logic [31:0] INIT_CYC = 32'(CLK_HZ / 100);
  localparam logic [31:0] DONE_CYC = 32'(CLK_HZ / 10);
  localparam logic [7:0]  PH_HI    = 8'(CCLK_HALF);
  localparam logic [7:0]  PH_END   = 8'(2 * CCLK_HALF - 1);

  localparam logic [2:0] E_MAGIC = 3'd1, E_LEN = 3'd2, E_NOREACT = 3'd3,
                         E_INIT = 3'd4, E_MIDLOAD = 3'd5, E_DONE = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_HRD, S_HCAP, S_CHK, S_PROG, S_INIT, S_FRD, S_FCAP, S_SHIFT, S_TAIL
  } st_t;

  st_t         st;
  logic [63:0] hdr;
  logic [2:0]  idx;
  logic [31:0] cnt, timer, tail_t;
  logic [7:0]  sh, ph;
  logic [2:0]  bitn;
  logic        pad, tail_on;
  logic [1:0]  init_q, done_q;

  wire init_s = init_q[1];
  wire done_s = done_q[1];
  wire [31:0] len = hdr[31:0];

  assign mem_rd   = (st == S_HRD) || (st == S_FRD && cnt != len);
  assign mem_addr = (st == S_HRD) ? ADDR_W'(idx) : ADDR_W'(cnt + 32'd8);
  assign cfg_cclk = (st == S_SHIFT) && (ph >= PH_HI);
  assign cfg_din  = (st == S_SHIFT) && sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hdr <= '0; idx <= '0; cnt <= '0; timer <= '0; tail_t <= '0;
      sh <= '0; ph <= '0; bitn <= '0; pad <= 1'b0; tail_on <= 1'b0;
      init_q <= '0; done_q <= '0;
      cfg_drive <= 1'b0; cfg_prog_b <= 1'b1;
      busy <= 1'b0; ok <= 1'b0; err <= 1'b0; err_code <= '0; done_warn <= 1'b0;
    end else begin
      init_q <= {init_q[0], cfg_init_b};
      done_q <= {done_q[0], cfg_done};
      if (tail_on) tail_t <= tail_t + 32'd1;
      case (st)
        S_IDLE: if (start) begin
          busy <= 1'b1; ok <= 1'b0; err <= 1'b0; err_code <= '0; done_warn <= 1'b0;
          idx <= '0; cnt <= '0; pad <= 1'b0; tail_on <= 1'b0;
          st <= S_HRD;
        end
        S_HRD: st <= S_HCAP;
        S_HCAP: begin
          hdr <= {hdr[55:0], mem_rdata};
          idx <= idx + 3'd1;
          st  <= (idx == 3'd7) ? S_CHK : S_HRD;
        end
        S_CHK: begin
          if (hdr[63:32] != MAGIC) begin
            st <= S_IDLE; busy <= 1'b0; err <= 1'b1; err_code <= E_MAGIC;
          end else if (len > MAX_LEN) begin
            st <= S_IDLE; busy <= 1'b0; err <= 1'b1; err_code <= E_LEN;
          end else begin
            done_warn <= done_s; cfg_drive <= 1'b1; cfg_prog_b <= 1'b0;
            timer <= '0; st <= S_PROG;
          end
        end
        S_PROG: begin
          if (timer == PROG_CYC - 32'd1) begin
            timer <= '0;
            if (init_s) begin
              st <= S_IDLE; busy <= 1'b0; err <= 1'b1; err_code <= E_NOREACT;
              cfg_drive <= 1'b0; cfg_prog_b <= 1'b1;
            end else begin
              cfg_prog_b <= 1'b1; st <= S_INIT;
            end
          end else timer <= timer + 32'd1;
        end
        S_INIT: begin
          if (timer == INIT_CYC - 32'd1) begin
            timer <= '0;
            if (!init_s) begin
              st <= S_IDLE; busy <= 1'b0; err <= 1'b1; err_code <= E_INIT;
              cfg_drive <= 1'b0;
            end else st <= S_FRD;
          end else timer <= timer + 32'd1;
        end
        S_FRD: begin
          if (cnt == len) begin
            tail_on <= 1'b1; tail_t <= '0; st <= S_TAIL;
          end else st <= S_FCAP;
        end
        S_FCAP: begin
          sh <= mem_rdata; ph <= '0; bitn <= '0; st <= S_SHIFT;
        end
        S_SHIFT: begin
          if (ph == PH_END) begin
            ph <= '0; sh <= {sh[6:0], 1'b0}; bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              if (pad) st <= S_TAIL;
              else if (!init_s) begin
                st <= S_IDLE; busy <= 1'b0; err <= 1'b1; err_code <= E_MIDLOAD;
                cfg_drive <= 1'b0;
              end else begin
                cnt <= cnt + 32'd1; st <= S_FRD;
              end
            end
          end else ph <= ph + 8'd1;
        end
        S_TAIL: begin
          if (done_s) begin
            st <= S_IDLE; busy <= 1'b0; ok <= 1'b1; cfg_drive <= 1'b0; tail_on <= 1'b0;
          end else if (tail_t >= DONE_CYC) begin
            st <= S_IDLE; busy <= 1'b0; err <= 1'b1; err_code <= E_DONE;
            cfg_drive <= 1'b0; tail_on <= 1'b0;
          end else begin
            sh <= 8'hFF; pad <= 1'b1; ph <= '0; bitn <= '0; st <= S_SHIFT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_drive_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HRD || st == S_HCAP || st == S_CHK) |-> !cfg_drive);
  p_prog_pins_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_drive && !cfg_prog_b) |-> (!cfg_cclk && !cfg_din));
  p_din_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_din));
  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ok ^ err));
  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, err, busy}));
  p_code_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_code));
endmodule

// File: tb/slave_cfg_loader_bench.sv
module slave_cfg_loader_bench;
  localparam int CLK_HZ = 20000;
  localparam int HALF = 2;
  localparam int AW = 8;
  localparam logic [31:0] MAXL = 32'd12;
  localparam logic [31:0] MAG = 32'h5352_544D;
  localparam int PROG_C = CLK_HZ / 1000;
  localparam int INIT_C = CLK_HZ / 100;
  localparam int DONE_C = CLK_HZ / 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  always #2 clk = ~clk;

  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] mem [0:63];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

  logic init_b = 1'b1, done = 1'b0;
  logic cfg_drive, cfg_prog_b, cfg_cclk, cfg_din, busy, ok, err, done_warn;
  logic [2:0] err_code;

  slave_cfg_loader #(.CLK_HZ(CLK_HZ), .CCLK_HALF(HALF), .ADDR_W(AW),
                     .MAGIC(MAG), .MAX_LEN(MAXL)) u_slave_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .cfg_drive(cfg_drive), .cfg_prog_b(cfg_prog_b),
    .cfg_cclk(cfg_cclk), .cfg_din(cfg_din), .cfg_init_b(init_b), .cfg_done(done),
    .busy(busy), .ok(ok), .err(err), .err_code(err_code), .done_warn(done_warn));

  int checks = 0, fails = 0, cyc = 0;
  int plow, nbytes, bitc, gap, since_rel, tailcyc, rel = 100;
  logic [7:0] cur = 8'h00;
  logic [7:0] got [$];
  logic pcclk = 1'b0, pprog = 1'b1, drv_seen = 1'b0;
  int m_mode = 0, drop_at = -1, done_tgt = -1, plen = 0;
  logic done_pre = 1'b0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 29 + 90);
  endfunction

  task automatic chk(bit good, string tag, int act, int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model of the target device and pin monitor, compared every clock
  always @(negedge clk) begin
    cyc++;
    if (start) begin
      plow = 0; nbytes = 0; bitc = 0; gap = -1; since_rel = -1; tailcyc = 0;
      got.delete(); drv_seen = 1'b0;
    end else begin
      if (cfg_drive) drv_seen = 1'b1;
      if (cfg_drive && !cfg_prog_b) plow++;
      if (cfg_prog_b && !pprog) since_rel = 0;
      else if (since_rel >= 0 && gap < 0) since_rel++;
      if (cfg_cclk && !pcclk) begin
        if (gap < 0 && since_rel >= 0) gap = since_rel;
        cur = {cur[6:0], cfg_din};
        bitc++;
        if (bitc == 8) begin got.push_back(cur); nbytes++; bitc = 0; end
      end
      if (busy && nbytes >= plen) tailcyc++;
      if (busy) begin
        checks++;
        if (cfg_drive && !cfg_prog_b && (cfg_cclk || cfg_din)) begin
          fails++;
          $display("FAIL R3 serial pins active during program pulse actual=%0d expected=0",
                   {cfg_cclk, cfg_din});
        end
      end
    end
    pcclk = cfg_cclk;
    pprog = cfg_prog_b;
    if (cfg_drive && !cfg_prog_b) rel = 0;
    else if (rel < 100) rel++;
    if (m_mode == 1) init_b = 1'b1;
    else if (m_mode == 2) init_b = 1'b0;
    else init_b = (rel >= 50) && !(drop_at >= 0 && nbytes >= drop_at);
    done = done_pre || (done_tgt >= 0 && nbytes >= done_tgt);
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic set_img(logic [31:0] magic, logic [31:0] len);
    for (int i = 0; i < 4; i++) begin
      mem[i]     = magic[31-8*i -: 8];
      mem[4 + i] = len[31-8*i -: 8];
    end
    for (int i = 0; i < 56; i++) mem[8 + i] = pat(i);
    plen = int'(len);
  endtask

  task automatic run();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int payload_bad(int n);
    int bad = 0;
    for (int i = 0; i < n && i < got.size(); i++) if (got[i] != pat(i)) bad++;
    return bad;
  endfunction

  function automatic int pad_bad(int from);
    int bad = 0;
    for (int i = from; i < got.size(); i++) if (got[i] != 8'hFF) bad++;
    return bad;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !ok && !err, "R11 reset status", {busy, ok, err}, 0);
    chk(err_code == 0 && !cfg_drive && !cfg_cclk, "R11 reset pins", {err_code, cfg_drive, cfg_cclk}, 0);
    #1 rst_n = 1'b1;

    // normal load, done after two fill bytes
    set_img(MAG, 10); m_mode = 0; drop_at = -1; done_tgt = 12; done_pre = 1'b0;
    run();
    chk(ok && !err && err_code == 0, "R8 success", {ok, err, err_code}, 8'b10_000);
    chk(plow == PROG_C, "R3 program pulse width", plow, PROG_C);
    chk(gap >= INIT_C, "R5 init wait before first clock", gap, INIT_C);
    chk(payload_bad(10) == 0 && got.size() >= 10, "R6 payload order and bit order", payload_bad(10), 0);
    chk(got.size() == 12 || got.size() == 13, "R8 fill byte count", got.size(), 12);
    chk(pad_bad(10) == 0, "R8 fill bytes are 0xFF", pad_bad(10), 0);
    chk(!done_warn, "R10 no warning", done_warn, 0);
    repeat (20) @(negedge clk);
    chk(ok && !busy && err_code == 0, "R11 status held", {ok, busy}, 2);

    // bad magic
    set_img(32'h5352_544E, 4); done_tgt = 4;
    run();
    chk(err && err_code == 1, "R1 bad magic code", err_code, 1);
    chk(!drv_seen && nbytes == 0 && plow == 0, "R1 no pin activity", drv_seen, 0);

    // length over limit, then at limit
    set_img(MAG, MAXL + 1); done_tgt = 13;
    run();
    chk(err && err_code == 2, "R2 length too large", err_code, 2);
    chk(!drv_seen, "R2 no pin activity", drv_seen, 0);
    set_img(MAG, MAXL); done_tgt = 12;
    run();
    chk(ok && err_code == 0 && payload_bad(12) == 0, "R2 length at limit accepted", err_code, 0);

    // init never falls
    set_img(MAG, 6); m_mode = 1; done_tgt = 6;
    run();
    chk(err && err_code == 3, "R4 no reaction to program", err_code, 3);
    chk(nbytes == 0 && bitc == 0 && plow == PROG_C, "R4 no serial clock", nbytes, 0);

    // init stuck low
    m_mode = 2;
    run();
    chk(err && err_code == 4, "R5 init not released", err_code, 4);
    chk(nbytes == 0 && bitc == 0, "R5 no serial clock", nbytes, 0);

    // init drops during payload
    set_img(MAG, 10); m_mode = 0; drop_at = 3; done_tgt = 10;
    run();
    chk(err && err_code == 5, "R7 init low mid load", err_code, 5);
    chk(nbytes >= 3 && nbytes <= 4, "R7 load stops early", nbytes, 3);
    drop_at = -1;

    // done never arrives
    set_img(MAG, 5); done_tgt = -1;
    run();
    chk(err && err_code == 6, "R9 done timeout code", err_code, 6);
    chk(tailcyc >= DONE_C && tailcyc <= DONE_C + 60, "R9 timeout length", tailcyc, DONE_C);
    chk(got.size() > 5 && pad_bad(5) == 0, "R9 fill bytes 0xFF", pad_bad(5), 0);

    // done already high
    set_img(MAG, 4); done_pre = 1'b1;
    run();
    chk(done_warn && ok && !err, "R10 warning with success", {done_warn, ok, err}, 6);
    chk(got.size() == 4 && payload_bad(4) == 0, "R10 no fill bytes", got.size(), 4);
    done_pre = 1'b0;

    // next start clears earlier status
    set_img(MAG, 3); done_tgt = 3;
    run();
    chk(ok && !done_warn && err_code == 0, "R11 status cleared by start", {done_warn, err_code}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule